// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is the data and direction path of an 8-pin general-purpose I/O port that sits on a 32-bit register bus. It holds an output latch and a direction register, drives per-pin output values and output enables, and samples the pins through a synchronizer so that software can read them back.

The data register is not a single word. It is a window of word addresses, and the address of each access selects which pins the access may touch. Address bits [9:2] form an 8-bit pin mask, with bit 2 for pin 0 and bit 9 for pin 7. A write changes only the latch bits that are enabled in that mask. A read returns zero for every disabled pin. Software can therefore set, clear or sample any subset of pins in one bus access, with no read-modify-write and no race against other code that uses the same port. The direction register sits at its own address just above the window.

Read data is registered. A read request in one cycle produces its data after the next rising clock edge, and that data holds until the next read.

Top module: `maskgpio_port`

## Requirements
- R1: Every word address from 0x000 to 0x3FC selects the data register. Address bits [9:2] give the pin mask, with bit 2 for pin 0 and bit 9 for pin 7.
- R2: A write into the data window loads `bus_wdata[i]` into latch bit i only where mask bit i is 1. Latch bits whose mask bit is 0 keep their value, and a write with an all-zero mask changes nothing.
- R3: A read from the data window returns 0 in every pin position whose mask bit is 0.
- R4: In a pin position whose mask bit is 1, a data read returns the latch bit when that pin's direction bit is 1 (output). It returns the synchronized pin level when the direction bit is 0 (input).
- R5: The direction register is at address 0x400. A write there loads `bus_wdata[7:0]`, where 1 means output, and a read there returns it in bits [7:0].
- R6: Reset clears the latch, the direction register and the read data. After reset every pin is an input, `pin_oe` is 0 and `pin_out` is 0.
- R7: `pin_oe[i]` equals direction bit i. `pin_out[i]` carries latch bit i when pin i is an output and is 0 when pin i is an input.
- R8: Read data bits [31:8] are always 0. A read at any address that is neither the data window nor 0x400 returns 0. A write at such an address changes neither the latch nor the direction register.
- R9: Pin inputs pass through two flops. After `pin_in` changes, reads sampled at the first and second rising edges still return the old level, and a read sampled at the third edge returns the new level.
- R10: A read requested in one cycle (`bus_sel`=1, `bus_wr`=0) puts its data on `bus_rdata` after the next rising edge. `bus_rdata` then holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access; bits [9:2] form the pin mask inside the data window |
| bus_wdata | input | 32 | Write data; only bits [7:0] are used |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Raw pin levels (asynchronous) |
| pin_out | output | 8 | Output value to the pads |
| pin_oe | output | 8 | Output enable to the pads |

## Verification
The embedded assertions check on every cycle the properties that hold cycle by cycle:
- A masked write touches only its enabled latch bits and loads the bus value into them.
- A direction write reaches `pin_oe` on the following cycle.
- A data read never carries a bit outside its mask, and the upper read bits stay zero.
- `bus_rdata` does not move without a read request.

Other behaviours need the bench's scenarios to show them:
- The per-pin choice between the latch and the synchronized pin in mixed-direction configurations.
- The exact two-flop latency of a pin change.
- Whether writes to unmapped addresses leave the registers alone.
- The values after a reset in the middle of a run.

// File: rtl/maskgpio_pkg.sv
package maskgpio_pkg;
   // Which register an access falls on
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_DIR  = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/maskgpio_decode.sv
module maskgpio_decode
   import maskgpio_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int PORT_W     = 8,
   parameter int DIR_OFFSET = 'h400
) (
   input  logic [ADDR_W-1:2] addr_word,
   output reg_sel_e          sel,
   output logic [PORT_W-1:0] mask
);
   localparam int WIN_BITS = PORT_W + 2;
   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

   generate
      if (ADDR_W <= WIN_BITS) begin : g_bad_addr
         $error("maskgpio_decode: ADDR_W must exceed PORT_W+2");
      end
      if (DIR_OFFSET < (1 << WIN_BITS)) begin : g_bad_dir
         $error("maskgpio_decode: direction register overlaps the data window");
      end
   endgenerate

   // mask bit i comes from address bit i+2
   assign mask = addr_word[WIN_BITS-1:2];

   always_comb begin
      if (addr_word[ADDR_W-1:WIN_BITS] == '0)
         sel = SEL_DATA;
      else if (addr_word == DIR_ADDR[ADDR_W-1:2])
         sel = SEL_DIR;
      else
         sel = SEL_NONE;
   end
endmodule

// File: rtl/maskgpio_sync.sv
module maskgpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("maskgpio_sync: STAGES must not be negative");
      end else if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stg[s] <= '0;
            end else begin
               stg[0] <= d;
               for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/maskgpio_pinbank.sv
module maskgpio_pinbank #(
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data_en,
   input  logic              wr_dir_en,
   input  logic [PORT_W-1:0] mask,
   input  logic [PORT_W-1:0] wdata,
   input  logic [PORT_W-1:0] pin_sync,
   output logic [PORT_W-1:0] dir_q,
   output logic [PORT_W-1:0] view,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_oe
);
   logic [PORT_W-1:0] latch_q;

   generate
      for (genvar i = 0; i < PORT_W; i++) begin : g_pin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               latch_q[i] <= 1'b0;
            else if (wr_data_en && mask[i])
               latch_q[i] <= wdata[i];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dir_q[i] <= 1'b0;
            else if (wr_dir_en)
               dir_q[i] <= wdata[i];
         end

         assign view[i]    = dir_q[i] ? latch_q[i] : pin_sync[i];
         assign pin_out[i] = dir_q[i] & latch_q[i];
         assign pin_oe[i]  = dir_q[i];
      end
   endgenerate

   // R2
   masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data_en |=> ((latch_q & ~$past(mask)) == ($past(latch_q) & ~$past(mask))));

   // R2
   masked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data_en |=> ((latch_q & $past(mask)) == ($past(wdata) & $past(mask))));

   // R5
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir_en |=> (pin_oe == $past(wdata)));
endmodule

// File: rtl/maskgpio_port.sv
module maskgpio_port
   import maskgpio_pkg::*;
#(
   parameter int BUS_W       = 32,
   parameter int ADDR_W      = 12,
   parameter int PORT_W      = 8,
   parameter int DIR_OFFSET  = 'h400,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_oe
);
   localparam int PAD_W = BUS_W - PORT_W;

   generate
      if (BUS_W <= PORT_W) begin : g_bad_bus
         $error("maskgpio_port: BUS_W must exceed PORT_W");
      end
   endgenerate

   reg_sel_e          sel;
   logic [PORT_W-1:0] mask;
   logic [PORT_W-1:0] pin_sync;
   logic [PORT_W-1:0] dir_q;
   logic [PORT_W-1:0] view;
   logic              rd_req;
   logic              wr_req;
   logic              unused_bits;

   assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:PORT_W]};
   assign rd_req = bus_sel && !bus_wr;
   assign wr_req = bus_sel && bus_wr;

   maskgpio_decode #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .DIR_OFFSET(DIR_OFFSET)
   ) u_decode (
      .addr_word (bus_addr[ADDR_W-1:2]),
      .sel       (sel),
      .mask      (mask)
   );

   maskgpio_sync #(
      .W(PORT_W), .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   maskgpio_pinbank #(
      .PORT_W(PORT_W)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_data_en (wr_req && (sel == SEL_DATA)),
      .wr_dir_en  (wr_req && (sel == SEL_DIR)),
      .mask       (mask),
      .wdata      (bus_wdata[PORT_W-1:0]),
      .pin_sync   (pin_sync),
      .dir_q      (dir_q),
      .view       (view),
      .pin_out    (pin_out),
      .pin_oe     (pin_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_req) begin
         unique case (sel)
            SEL_DATA: bus_rdata <= {{PAD_W{1'b0}}, view & mask};
            SEL_DIR:  bus_rdata <= {{PAD_W{1'b0}}, dir_q};
            default:  bus_rdata <= '0;
         endcase
      end
   end

   // R3
   read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && sel == SEL_DATA) |=> ((bus_rdata[PORT_W-1:0] & ~$past(mask)) == '0));

   // R8
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[BUS_W-1:PORT_W] == '0);

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(bus_rdata));
endmodule

// File: tb/tb_maskgpio_port.sv
module tb_maskgpio_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;
   logic [7:0]  pin_oe;

   always #5 clk = ~clk;

   maskgpio_port dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_seen = 1'b0;
   logic [7:0]  m_latch = '0, m_dir = '0, m_pin = '0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected read result per completed read
   always @(posedge clk) rd_seen <= rst_n && bus_sel && !bus_wr;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, bus_rdata, e);
      end
   end

   function automatic logic [31:0] model_read(logic [11:0] a);
      logic [7:0] mk;
      mk = a[9:2];
      if (a[11:10] == 2'b00)
         return {24'h0, ((m_latch & m_dir) | (m_pin & ~m_dir)) & mk};
      else if (a[11:2] == 10'h100)
         return {24'h0, m_dir};
      return 32'h0;
   endfunction

   task automatic bus_write(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      if (a[11:10] == 2'b00)
         m_latch = (m_latch & ~a[9:2]) | (d[7:0] & a[9:2]);
      else if (a[11:2] == 10'h100)
         m_dir = d[7:0];
   endtask

   task automatic bus_read(logic [11:0] a, string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic set_pins(logic [7:0] v);
      @(negedge clk);
      pin_in = v;
      m_pin = v;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 rdata after reset", bus_rdata, 32'h0);
      check("R6 pin_oe after reset", {24'h0, pin_oe}, 32'h0);
      check("R6 pin_out after reset", {24'h0, pin_out}, 32'h0);
      bus_read(12'h400, "R6 dir reads 0 after reset");

      set_pins(8'h5A);
      bus_read(12'h3FC, "R1 R4 full-mask read of inputs");

      bus_write(12'h3FC, 32'h0000_00A5);
      check("R7 pin_out while inputs", {24'h0, pin_out}, 32'h0);
      check("R7 pin_oe while inputs", {24'h0, pin_oe}, 32'h0);
      bus_read(12'h3FC, "R4 inputs ignore latch");

      bus_write(12'h400, 32'h0000_00FF);
      check("R5 R7 pin_oe all outputs", {24'h0, pin_oe}, 32'hFF);
      check("R7 pin_out latch", {24'h0, pin_out}, 32'hA5);
      bus_read(12'h400, "R5 dir readback");
      bus_read(12'h3FC, "R4 outputs read latch");

      bus_write(12'h03C, 32'hFFFF_FF00);
      check("R2 low-nibble masked write", {24'h0, pin_out}, {24'h0, m_latch});
      check("R2 expected A0", {24'h0, m_latch}, 32'hA0);
      bus_write(12'h000, 32'h0000_00FF);
      check("R2 zero-mask write no change", {24'h0, pin_out}, 32'hA0);

      bus_read(12'h3C0, "R3 high-nibble mask");
      bus_read(12'h03C, "R3 low-nibble mask");
      bus_read(12'h2A8, "R3 alternating mask");

      bus_write(12'h400, 32'h0000_000F);
      set_pins(8'h3C);
      bus_read(12'h3FC, "R4 mixed directions");
      check("R7 pin_oe mixed", {24'h0, pin_oe}, 32'h0F);
      check("R7 pin_out mixed", {24'h0, pin_out}, {24'h0, m_latch & 8'h0F});

      bus_write(12'h404, 32'h0000_0000);
      bus_read(12'h400, "R8 dir unchanged by unmapped write");
      bus_write(12'h800, 32'h0000_0000);
      bus_read(12'hC04, "R8 unmapped read is zero");
      bus_write(12'h3FC, 32'hFFFF_FF0A);
      bus_read(12'h3FC, "R8 upper read bits zero");

      // R9: three back-to-back reads right after a pin change
      @(negedge clk);
      pin_in = 8'hC3;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h3FC;
      exp_q.push_back(model_read(12'h3FC)); tag_q.push_back("R9 first edge old level");
      @(negedge clk);
      exp_q.push_back(model_read(12'h3FC)); tag_q.push_back("R9 second edge old level");
      @(negedge clk);
      m_pin = 8'hC3;
      exp_q.push_back(model_read(12'h3FC)); tag_q.push_back("R9 third edge new level");
      @(negedge clk);
      bus_sel = 1'b0;

      // R10: data holds without a read
      repeat (3) @(negedge clk);
      bus_write(12'h3FC, 32'h0000_0055);
      check("R10 rdata held", bus_rdata, {24'h0, 8'h0A | (8'hC3 & 8'hF0)});

      @(negedge clk);
      rst_n = 1'b0;
      m_latch = '0; m_dir = '0;
      repeat (2) @(negedge clk);
      check("R6 mid-run reset pin_oe", {24'h0, pin_oe}, 32'h0);
      check("R6 mid-run reset pin_out", {24'h0, pin_out}, 32'h0);
      check("R6 mid-run reset rdata", bus_rdata, 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      bus_read(12'h400, "R6 dir cleared");
      bus_read(12'h3FC, "R6 pins are inputs");

      repeat (2) @(negedge clk);
      check("all expected reads consumed", exp_q.size(), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule